// File: doc/BRIEF.md
# Pulse Induction Gate Timer

This block derives the three repeating control levels of a pulse induction metal detector front end from a single system clock. The levels are a coil-switch transmit pulse, a sample gate that opens a short, adjustable time after the transmit pulse ends, and an audio chop gate. All three run at one shared repetition period, which is 13333 ticks by default: 600 Hz from an 8 MHz clock, so one tick is 0.125 µs.

The sample delay comes from a small unsigned setting, normally a digitized potentiometer reading. The setting is converted into ticks as a fixed minimum plus a per-step increment. It is captured only at a period boundary, so no period ever carries a partial or doubled sample pulse. The delay is also limited so that the sample gate cannot run past the end of the period. The transmit width, sample width and audio window are fixed parameters. The audio window is placed on its own, away from the transmit edge. Every output comes straight from a flop.

Top module: `pi_pulse_timer`

## Requirements
- R1: While `rst` is high, all three gates are low at the next clock edge and stay low. The first clock edge with `rst` low starts a new period: `tx_gate` is high from that edge on.
- R2: `tx_gate` is high for exactly `TX_TICKS` cycles at the start of every period. Consecutive rising edges of `tx_gate` are exactly `PERIOD_TICKS` cycles apart.
- R3: Counting the first transmit cycle as period index 0, `smp_gate` rises at index `TX_TICKS + D`, where D = `DLY_MIN_TICKS + dly_set * DLY_STEP_TICKS` and `dly_set` is read as an unsigned binary number. It stays high for exactly `SMP_TICKS` cycles.
- R4: `dly_set` is sampled only on the clock edge that starts a period. A change made at any other time affects only the following period.
- R5: D is limited to `PERIOD_TICKS - TX_TICKS - SMP_TICKS`, so the sample gate ends at or before the end of its period. `smp_gate` and `tx_gate` are never high in the same cycle.
- R6: `aud_gate` is high at period indices `AUD_START_TICKS` through `AUD_START_TICKS + AUD_TICKS - 1` in every period, whatever the value of `dly_set`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; one tick of timing resolution |
| rst | input | 1 | Synchronous active-high reset |
| dly_set | input | SET_W | Unsigned sample-delay setting, captured at period start |
| tx_gate | output | 1 | Coil-switch transmit pulse |
| smp_gate | output | 1 | Delayed, narrower sample-gate pulse |
| aud_gate | output | 1 | Audio chop gate, same period as the transmit pulse |

## Verification
The setting is stepped through several values: zero, mid-range values and the two largest codes. Because the sample rise moves by one step per code, an error in the offset, the scaling or the step size shows up in the measured start index. The setting is also changed in the middle of each period, after the transmit pulse and before the sample gate. This separates a delay that is captured at the boundary from one that follows the input at once. The largest code drives the raw delay past the limit and the next code lands just under it, which exposes a missing or misplaced clamp. A reset in the middle of a period, followed by a full period, checks that the timing restarts cleanly from the transmit pulse. A reference model written with plain integers follows every cycle, so a stray gate cycle anywhere in the period is also caught.

// File: rtl/pi_timer_pkg.sv
package pi_timer_pkg;

    typedef struct packed {
        logic tx;
        logic smp;
        logic aud;
    } pi_gates_t;

endpackage

// File: rtl/pi_period_counter.sv
module pi_period_counter #(
    parameter int PERIOD_TICKS = 13333,
    parameter int CNT_W        = 14
) (
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] cnt_next_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_TICKS - 1);

    always_comb begin
        wrap_o     = (cnt_i == LAST);
        cnt_next_o = wrap_o ? '0 : cnt_i + 1'b1;
    end
endmodule

// File: rtl/pi_delay_map.sv
module pi_delay_map #(
    parameter int SET_W          = 8,
    parameter int CNT_W          = 14,
    parameter int DLY_MIN_TICKS  = 120,
    parameter int DLY_STEP_TICKS = 4,
    parameter int DLY_MAX_TICKS  = 12773
) (
    input  logic [SET_W-1:0] set_i,
    output logic [CNT_W-1:0] dly_o
);
    localparam int WW = SET_W + CNT_W + 4;
    localparam logic [WW-1:0] MIN_W  = WW'(DLY_MIN_TICKS);
    localparam logic [WW-1:0] STEP_W = WW'(DLY_STEP_TICKS);
    localparam logic [WW-1:0] MAX_W  = WW'(DLY_MAX_TICKS);

    logic [WW-1:0] raw;

    always_comb begin
        raw   = MIN_W + WW'(set_i) * STEP_W;
        dly_o = (raw > MAX_W) ? CNT_W'(MAX_W) : CNT_W'(raw);
    end
endmodule

// File: rtl/pi_window.sv
module pi_window #(
    parameter int CNT_W = 14,
    parameter int LEN   = 1
) (
    input  logic [CNT_W-1:0] pos_i,
    input  logic [CNT_W-1:0] start_i,
    output logic             hit_o
);
    localparam int WW = CNT_W + 1;
    localparam logic [WW-1:0] LEN_W = WW'(LEN);

    logic [WW-1:0] pos_w;
    logic [WW-1:0] lo_w;
    logic [WW-1:0] hi_w;

    always_comb begin
        pos_w = {1'b0, pos_i};
        lo_w  = {1'b0, start_i};
        hi_w  = lo_w + LEN_W;
        hit_o = (pos_w >= lo_w) && (pos_w < hi_w);
    end
endmodule

// File: rtl/pi_pulse_timer.sv
module pi_pulse_timer
    import pi_timer_pkg::*;
#(
    parameter int PERIOD_TICKS    = 13333,
    parameter int TX_TICKS        = 400,
    parameter int SMP_TICKS       = 160,
    parameter int DLY_MIN_TICKS   = 120,
    parameter int DLY_STEP_TICKS  = 4,
    parameter int SET_W           = 8,
    parameter int AUD_START_TICKS = 6000,
    parameter int AUD_TICKS       = 3000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] dly_set,
    output logic             tx_gate,
    output logic             smp_gate,
    output logic             aud_gate
);
    localparam int CNT_W         = $clog2(PERIOD_TICKS);
    localparam int DLY_MAX_TICKS = PERIOD_TICKS - TX_TICKS - SMP_TICKS;
    localparam logic [CNT_W-1:0] TX_START  = '0;
    localparam logic [CNT_W-1:0] TX_LEN_C  = CNT_W'(TX_TICKS);
    localparam logic [CNT_W-1:0] AUD_START = CNT_W'(AUD_START_TICKS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] dly;
        pi_gates_t        gates;
    } state_t;

    localparam state_t RESET_ST = '{
        cnt:   CNT_W'(PERIOD_TICKS - 1),
        dly:   '0,
        gates: '{tx: 1'b0, smp: 1'b0, aud: 1'b0}
    };

    state_t st_d, st_q;

    logic [CNT_W-1:0] cnt_next;
    logic             wrap;
    logic [CNT_W-1:0] dly_map;
    logic [CNT_W-1:0] dly_next;
    logic [CNT_W-1:0] smp_start;
    logic             tx_hit, smp_hit, aud_hit;

    pi_period_counter #(
        .PERIOD_TICKS(PERIOD_TICKS),
        .CNT_W       (CNT_W)
    ) u_cnt (
        .cnt_i     (st_q.cnt),
        .cnt_next_o(cnt_next),
        .wrap_o    (wrap)
    );

    pi_delay_map #(
        .SET_W         (SET_W),
        .CNT_W         (CNT_W),
        .DLY_MIN_TICKS (DLY_MIN_TICKS),
        .DLY_STEP_TICKS(DLY_STEP_TICKS),
        .DLY_MAX_TICKS (DLY_MAX_TICKS)
    ) u_map (
        .set_i(dly_set),
        .dly_o(dly_map)
    );

    // The setting only enters at the edge that opens a new period.
    assign dly_next  = wrap ? dly_map : st_q.dly;
    assign smp_start = TX_LEN_C + dly_next;

    pi_window #(.CNT_W(CNT_W), .LEN(TX_TICKS)) u_tx_win (
        .pos_i(cnt_next), .start_i(TX_START), .hit_o(tx_hit)
    );

    pi_window #(.CNT_W(CNT_W), .LEN(SMP_TICKS)) u_smp_win (
        .pos_i(cnt_next), .start_i(smp_start), .hit_o(smp_hit)
    );

    pi_window #(.CNT_W(CNT_W), .LEN(AUD_TICKS)) u_aud_win (
        .pos_i(cnt_next), .start_i(AUD_START), .hit_o(aud_hit)
    );

    always_comb begin
        st_d           = st_q;
        st_d.cnt       = cnt_next;
        st_d.dly       = dly_next;
        st_d.gates.tx  = tx_hit;
        st_d.gates.smp = smp_hit;
        st_d.gates.aud = aud_hit;
        if (rst) begin
            st_d = RESET_ST;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign tx_gate  = st_q.gates.tx;
    assign smp_gate = st_q.gates.smp;
    assign aud_gate = st_q.gates.aud;
endmodule

// File: rtl/pi_pulse_timer_chk.sv
module pi_pulse_timer_chk #(
    parameter int PERIOD_TICKS = 13333,
    parameter int TX_TICKS     = 400,
    parameter int SMP_TICKS    = 160,
    parameter int AUD_TICKS    = 3000
) (
    input logic clk,
    input logic rst,
    input logic tx,
    input logic smp,
    input logic aud
);
    logic [31:0] tx_run, smp_run, aud_run, gap;
    logic        seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_run  <= '0;
            smp_run <= '0;
            aud_run <= '0;
            gap     <= '0;
            seen    <= 1'b0;
        end else begin
            tx_run  <= tx  ? tx_run + 1  : '0;
            smp_run <= smp ? smp_run + 1 : '0;
            aud_run <= aud ? aud_run + 1 : '0;
            if (tx && !seen) begin
                seen <= 1'b1;
                gap  <= 32'd1;
            end else if (seen && tx && tx_run == 0) begin
                gap <= 32'd1;
            end else begin
                gap <= gap + 1;
            end
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!tx && !smp && !aud));

    a_r1_restart_tx: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |=> tx);

    a_r2_tx_width: assert property (@(posedge clk) disable iff (rst)
        $fell(tx) |-> (tx_run == TX_TICKS));

    a_r2_period: assert property (@(posedge clk) disable iff (rst)
        ($rose(tx) && seen) |-> (gap == PERIOD_TICKS));

    a_r3_smp_width: assert property (@(posedge clk) disable iff (rst)
        $fell(smp) |-> (smp_run == SMP_TICKS));

    a_r5_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(tx && smp));

    a_r6_aud_width: assert property (@(posedge clk) disable iff (rst)
        $fell(aud) |-> (aud_run == AUD_TICKS));
endmodule

bind pi_pulse_timer pi_pulse_timer_chk #(
    .PERIOD_TICKS(PERIOD_TICKS),
    .TX_TICKS    (TX_TICKS),
    .SMP_TICKS   (SMP_TICKS),
    .AUD_TICKS   (AUD_TICKS)
) u_chk (
    .clk(clk),
    .rst(rst),
    .tx (tx_gate),
    .smp(smp_gate),
    .aud(aud_gate)
);

// File: tb/pi_pulse_timer_tb.sv
module pi_pulse_timer_tb;
    localparam int CLK_P = 10;
    localparam int P     = 60;
    localparam int TXT   = 20;
    localparam int SMPT  = 8;
    localparam int DMIN  = 3;
    localparam int DSTEP = 2;
    localparam int SW    = 4;
    localparam int AST   = 44;
    localparam int ALEN  = 10;
    localparam int DMAX  = P - TXT - SMPT;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [SW-1:0] dly_set = '0;
    logic          tx_gate, smp_gate, aud_gate;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    pi_pulse_timer #(
        .PERIOD_TICKS(P), .TX_TICKS(TXT), .SMP_TICKS(SMPT),
        .DLY_MIN_TICKS(DMIN), .DLY_STEP_TICKS(DSTEP), .SET_W(SW),
        .AUD_START_TICKS(AST), .AUD_TICKS(ALEN)
    ) u_dut (
        .clk(clk), .rst(rst), .dly_set(dly_set),
        .tx_gate(tx_gate), .smp_gate(smp_gate), .aud_gate(aud_gate)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic int exp_delay(int s);
        int d = DMIN + s * DSTEP;
        return (d > DMAX) ? DMAX : d;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference: period index and captured delay as integers.
    int  m_idx = P - 1;
    int  m_dly = 0;
    bit  m_tx = 0, m_smp = 0, m_aud = 0;
    bit  model_on = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            m_idx = P - 1;
            m_dly = 0;
            m_tx = 0; m_smp = 0; m_aud = 0;
        end else begin
            m_idx = (m_idx + 1) % P;
            if (m_idx == 0) m_dly = exp_delay(int'(dly_set));
            m_tx  = (m_idx < TXT);
            m_smp = (m_idx >= TXT + m_dly) && (m_idx < TXT + m_dly + SMPT);
            m_aud = (m_idx >= AST) && (m_idx < AST + ALEN);
        end
    end

    always @(negedge clk) begin
        if (model_on) begin
            check("R2", "model tx_gate", int'(tx_gate), int'(m_tx));
            check("R3", "model smp_gate", int'(smp_gate), int'(m_smp));
            check("R6", "model aud_gate", int'(aud_gate), int'(m_aud));
        end
    end

    // One full period, starting at the negedge of index 0; new_set is applied after the transmit pulse.
    task automatic run_period(int set_now, int new_set);
        int tx_ones = 0, tx_lead = 0, smp_first = -1, smp_ones = 0;
        int aud_first = -1, aud_ones = 0, overlap = 0, tail = 0;
        int d = exp_delay(set_now);
        for (int k = 0; k < P; k++) begin
            @(negedge clk);
            if (k == TXT) dly_set = SW'(new_set);
            if (tx_gate) tx_ones++;
            if (tx_gate && k < TXT) tx_lead++;
            if (smp_gate && smp_first < 0) smp_first = k;
            if (smp_gate) smp_ones++;
            if (aud_gate && aud_first < 0) aud_first = k;
            if (aud_gate) aud_ones++;
            if (tx_gate && smp_gate) overlap++;
            if (smp_gate && k >= TXT + d + SMPT) tail++;
        end
        check("R2", "tx high cycles", tx_ones, TXT);
        check("R2", "tx high at period head", tx_lead, TXT);
        check("R3", "sample start index", smp_first, TXT + d);
        check("R3", "sample width", smp_ones, SMPT);
        check("R4", "sample uses setting from boundary", smp_first - TXT, d);
        check("R5", "tx/sample overlap cycles", overlap, 0);
        check("R5", "sample past its window", tail, 0);
        check("R6", "audio start index", aud_first, AST);
        check("R6", "audio width", aud_ones, ALEN);
    endtask

    initial begin
        rst = 1'b1;
        dly_set = '0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (i > 0) begin
                check("R1", "tx low in reset", int'(tx_gate), 0);
                check("R1", "smp low in reset", int'(smp_gate), 0);
                check("R1", "aud low in reset", int'(aud_gate), 0);
            end
        end
        rst = 1'b0;
        model_on = 1'b1;
        // R1: the first edge after release must open a transmit pulse (checked at k=0 inside run_period).
        run_period(0, 5);
        run_period(5, 9);
        run_period(9, 15);
        run_period(15, 14);   // R5: raw delay 33 clamps to 32
        run_period(14, 0);    // R5: raw delay 31 stays under the limit
        run_period(0, 0);
        // Reset in the middle of a period.
        for (int i = 0; i < 17; i++) @(negedge clk);
        rst = 1'b1;
        dly_set = SW'(7);
        @(negedge clk);
        check("R1", "tx low after mid-period reset", int'(tx_gate), 0);
        check("R1", "smp low after mid-period reset", int'(smp_gate), 0);
        check("R1", "aud low after mid-period reset", int'(aud_gate), 0);
        @(negedge clk);
        rst = 1'b0;
        run_period(7, 3);
        run_period(3, 3);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule